// File: doc/BRIEF.md
# Masked-Match Address Rewrite Windows

This block translates local request addresses into a wider target address space through a bank of programmable windows. Each window holds a control word and three page-granular values: a mask, a match pattern and a replacement. A 40-bit request address, tagged with the identity of the requester, is compared in parallel against every enabled window. The comparison covers address bits [39:20], so each window works on 1 MiB pages. A mask bit of 1 makes the matching address bit take part in the compare.

When a window hits, the page bits of the request are replaced by the window's 44-bit replacement value. The low 20 bits pass through, which yields a 64-bit target address. A window can also be restricted to the local core, to coprocessors, or to one coprocessor picked by its 3-bit id. If several windows hit, the lowest-numbered one wins. A request that hits nothing leaves zero-extended and is flagged as a miss. Responses appear one clock after the request.

Software programs the windows through a simple word-wide register port with a 16-bit byte address. To reconfigure a window, software clears its enable bit, rewrites the fields, and sets the enable bit again.

Top module: `xlat_window_bank`

## Requirements
- R1: There are 40 windows. Window i occupies 0x1C bytes starting at byte address 0x2000 + i*0x1C. The word offsets inside a window are: control at +0x00, mask low +0x04, mask high +0x08, match low +0x0C, match high +0x10, replacement low +0x14, replacement high +0x18.
- R2: The control word holds these fields: enable in bit 0, core-only in bit 1, coprocessor-only in bit 2, single-coprocessor enable in bit 3, and coprocessor select in bits [6:4]. Bits [31:7] read as zero. Every register resets to zero.
- R3: The mask low and match low words keep address bits [31:20] in register bits [31:20]. The mask high and match high words keep address bits [39:32] in register bits [7:0]. All other bits read as zero.
- R4: The replacement low word keeps target bits [31:20] in register bits [31:20]. The replacement high word keeps target bits [63:32] in register bits [31:0]. The full 44-bit replacement reaches the output.
- R5: A request hits window i when three conditions hold: the window is enabled, the requester gate allows the request, and (addr & mask) equals (match & mask) over bits [39:20]. Mask bits that are 0 are ignored in the compare.
- R6: On a hit, the response address is {replacement[63:20], request addr[19:0]} and the miss flag is low. The response appears on the clock edge after the request.
- R7: On a miss, the response address is the request address zero-extended to 64 bits, the miss flag is high, and the reported window index is 0.
- R8: A window whose enable bit is clear never hits, whatever its other fields hold.
- R9: When several windows hit, the response uses the lowest-numbered one and reports that index.
- R10: With core-only set, only requests that have req_is_core=1 can hit the window.
- R11: With coprocessor-only set, only requests that have req_is_core=0 can hit the window.
- R12: With single-coprocessor enable set, only a coprocessor request (req_is_core=0) whose req_cpid equals the select field can hit the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register byte address (read and write) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 40 | Local request address |
| req_is_core | input | 1 | 1: local core, 0: coprocessor |
| req_cpid | input | 3 | Coprocessor id |
| rsp_valid | output | 1 | Response strobe, one cycle after req_valid |
| rsp_addr | output | 64 | Translated or passed-through address |
| rsp_miss | output | 1 | No window hit |
| rsp_win | output | 6 | Index of the winning window |

## Verification
The bench builds the block with its default parameters: 40 windows, 1 MiB pages, a 40-bit request address and a 64-bit target. With these values the last window, number 39, sits at byte 0x2444. The bench reaches it directly, and it uses it to check that replacement bits above bit 39 make it to the output. The same values let the bench pit a low-numbered window against a higher one that matches the same page, and show that partial masks compare only the upper page bits. They also let it walk every requester gate with a fixed coprocessor select of 5.

// File: rtl/xwb_pkg.sv
package xwb_pkg;
  typedef struct packed {
    logic [2:0] cp_sel;
    logic       single_en;
    logic       cop_only;
    logic       core_only;
    logic       valid;
  } win_ctrl_t;

  localparam int CTRL_W = 7;

  localparam logic [15:0] OFS_CTRL  = 16'h00;
  localparam logic [15:0] OFS_MSKL  = 16'h04;
  localparam logic [15:0] OFS_MSKH  = 16'h08;
  localparam logic [15:0] OFS_MATL  = 16'h0C;
  localparam logic [15:0] OFS_MATH  = 16'h10;
  localparam logic [15:0] OFS_REPL  = 16'h14;
  localparam logic [15:0] OFS_REPH  = 16'h18;
endpackage

// File: rtl/xwb_win_regs.sv
module xwb_win_regs
  import xwb_pkg::*;
#(
  parameter int          CMP_W     = 20,
  parameter int          REPL_W    = 44,
  parameter int          LO_W      = 12,
  parameter logic [15:0] BASE      = 16'h2000,
  parameter int          STRIDE    = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [15:0]       addr,
  input  logic [31:0]       wdata,
  output win_ctrl_t         ctrl,
  output logic [CMP_W-1:0]  mask,
  output logic [CMP_W-1:0]  match,
  output logic [REPL_W-1:0] repl,
  output logic [31:0]       rdata
);
  localparam int CHI_W = CMP_W - LO_W;
  localparam int RHI_W = REPL_W - LO_W;

  logic [15:0] ofs;
  logic        hit_rng;

  assign ofs     = addr - BASE;
  assign hit_rng = (addr >= BASE) && (ofs < 16'(STRIDE)) && (addr[1:0] == 2'b00);

  win_ctrl_t         ctrl_d;
  logic [CMP_W-1:0]  mask_d, match_d;
  logic [REPL_W-1:0] repl_d;
  logic              en;

  assign en = wr && hit_rng;

  always_comb begin
    ctrl_d  = ctrl;
    mask_d  = mask;
    match_d = match;
    repl_d  = repl;
    unique case (ofs)
      OFS_CTRL: ctrl_d = win_ctrl_t'(wdata[CTRL_W-1:0]);
      OFS_MSKL: mask_d[LO_W-1:0]       = wdata[31:32-LO_W];
      OFS_MSKH: mask_d[CMP_W-1:LO_W]   = wdata[CHI_W-1:0];
      OFS_MATL: match_d[LO_W-1:0]      = wdata[31:32-LO_W];
      OFS_MATH: match_d[CMP_W-1:LO_W]  = wdata[CHI_W-1:0];
      OFS_REPL: repl_d[LO_W-1:0]       = wdata[31:32-LO_W];
      OFS_REPH: repl_d[REPL_W-1:LO_W]  = wdata[RHI_W-1:0];
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      mask  <= '0;
      match <= '0;
      repl  <= '0;
    end else if (en) begin
      ctrl  <= ctrl_d;
      mask  <= mask_d;
      match <= match_d;
      repl  <= repl_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_rng) begin
      unique case (ofs)
        OFS_CTRL: rdata[CTRL_W-1:0]   = ctrl;
        OFS_MSKL: rdata[31:32-LO_W]   = mask[LO_W-1:0];
        OFS_MSKH: rdata[CHI_W-1:0]    = mask[CMP_W-1:LO_W];
        OFS_MATL: rdata[31:32-LO_W]   = match[LO_W-1:0];
        OFS_MATH: rdata[CHI_W-1:0]    = match[CMP_W-1:LO_W];
        OFS_REPL: rdata[31:32-LO_W]   = repl[LO_W-1:0];
        OFS_REPH: rdata[RHI_W-1:0]    = repl[REPL_W-1:LO_W];
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/xwb_win_match.sv
module xwb_win_match
  import xwb_pkg::*;
#(
  parameter int CMP_W  = 20,
  parameter int CPID_W = 3
) (
  input  win_ctrl_t         ctrl,
  input  logic [CMP_W-1:0]  mask,
  input  logic [CMP_W-1:0]  match,
  input  logic [CMP_W-1:0]  page,
  input  logic              is_core,
  input  logic [CPID_W-1:0] cpid,
  output logic              hit
);
  logic addr_ok, gate_ok;

  assign addr_ok = ((page ^ match) & mask) == '0;

  always_comb begin
    gate_ok = 1'b1;
    if (ctrl.core_only && !is_core) gate_ok = 1'b0;
    if (ctrl.cop_only  &&  is_core) gate_ok = 1'b0;
    if (ctrl.single_en && (is_core || (cpid != ctrl.cp_sel))) gate_ok = 1'b0;
  end

  assign hit = ctrl.valid && gate_ok && addr_ok;
endmodule

// File: rtl/xwb_hit_select.sv
module xwb_hit_select #(
  parameter int NUM_WIN = 40,
  parameter int IDX_W   = 6
) (
  input  logic [NUM_WIN-1:0] hits,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hits[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/xlat_window_bank.sv
module xlat_window_bank
  import xwb_pkg::*;
#(
  parameter int NUM_WIN    = 40,
  parameter int WIN_BASE   = 'h2000,
  parameter int WIN_STRIDE = 'h1C,
  parameter int PAGE_LSB   = 20,
  parameter int LOCAL_AW   = 40,
  parameter int TGT_AW     = 64,
  parameter int CPID_W     = 3,
  localparam int IDX_W     = $clog2(NUM_WIN)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [15:0]         reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic                req_valid,
  input  logic [LOCAL_AW-1:0] req_addr,
  input  logic                req_is_core,
  input  logic [CPID_W-1:0]   req_cpid,
  output logic                rsp_valid,
  output logic [TGT_AW-1:0]   rsp_addr,
  output logic                rsp_miss,
  output logic [IDX_W-1:0]    rsp_win
);
  localparam int CMP_W  = LOCAL_AW - PAGE_LSB;
  localparam int REPL_W = TGT_AW - PAGE_LSB;
  localparam int LO_W   = 32 - PAGE_LSB;

  // reset: asynchronous assert, synchronous release
  logic rst_s1, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      rst_s1  <= 1'b1;
      rst_q_n <= rst_s1;
    end
  end

  win_ctrl_t         ctrl_a  [NUM_WIN];
  logic [CMP_W-1:0]  mask_a  [NUM_WIN];
  logic [CMP_W-1:0]  match_a [NUM_WIN];
  logic [REPL_W-1:0] repl_a  [NUM_WIN];
  logic [31:0]       rd_a    [NUM_WIN];
  logic [NUM_WIN-1:0] hits;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    xwb_win_regs #(
      .CMP_W (CMP_W), .REPL_W(REPL_W), .LO_W(LO_W),
      .BASE  (16'(WIN_BASE + g*WIN_STRIDE)), .STRIDE(WIN_STRIDE)
    ) regs_i (
      .clk(clk), .rst_n(rst_q_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .ctrl(ctrl_a[g]), .mask(mask_a[g]), .match(match_a[g]), .repl(repl_a[g]),
      .rdata(rd_a[g])
    );
    xwb_win_match #(.CMP_W(CMP_W), .CPID_W(CPID_W)) match_i (
      .ctrl(ctrl_a[g]), .mask(mask_a[g]), .match(match_a[g]),
      .page(req_addr[LOCAL_AW-1:PAGE_LSB]), .is_core(req_is_core), .cpid(req_cpid),
      .hit(hits[g])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_WIN; i++) reg_rdata = reg_rdata | rd_a[i];
  end

  logic             any_hit;
  logic [IDX_W-1:0] win_idx;

  xwb_hit_select #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) sel_i (
    .hits(hits), .any(any_hit), .idx(win_idx)
  );

  logic [TGT_AW-1:0] rsp_addr_d;
  always_comb begin
    if (any_hit) rsp_addr_d = {repl_a[win_idx], req_addr[PAGE_LSB-1:0]};
    else         rsp_addr_d = {{(TGT_AW-LOCAL_AW){1'b0}}, req_addr};
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_miss  <= 1'b0;
      rsp_win   <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_addr <= rsp_addr_d;
        rsp_miss <= !any_hit;
        rsp_win  <= win_idx;
      end
    end
  end
endmodule

// File: rtl/xlat_window_bank_chk.sv
module xlat_window_bank_chk #(
  parameter int WIN_BASE = 'h2000,
  parameter int LOCAL_AW = 40,
  parameter int TGT_AW   = 64,
  parameter int PAGE_LSB = 20,
  parameter int IDX_W    = 6
) (
  input logic                clk,
  input logic                rst_q_n,
  input logic [15:0]         reg_addr,
  input logic [31:0]         reg_rdata,
  input logic                req_valid,
  input logic [LOCAL_AW-1:0] req_addr,
  input logic                rsp_valid,
  input logic [TGT_AW-1:0]   rsp_addr,
  input logic                rsp_miss,
  input logic [IDX_W-1:0]    rsp_win
);
  // R6: a response follows every request one edge later
  a_r6_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_q_n)
    req_valid |=> rsp_valid);
  a_r6_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_q_n)
    !req_valid |=> !rsp_valid);
  // R6: the page offset survives translation
  a_r6_offset_kept: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rsp_valid && !rsp_miss) |-> rsp_addr[PAGE_LSB-1:0] == $past(req_addr[PAGE_LSB-1:0]));
  // R7: a miss passes the address through zero-extended
  a_r7_miss_passthru: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rsp_valid && rsp_miss) |-> rsp_addr == {{(TGT_AW-LOCAL_AW){1'b0}}, $past(req_addr)});
  a_r7_miss_win_zero: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rsp_valid && rsp_miss) |-> rsp_win == '0);
  // R2: reserved control bits read as zero
  a_r2_ctrl_reserved: assert property (@(posedge clk) disable iff (!rst_q_n)
    (reg_addr == 16'(WIN_BASE)) |-> reg_rdata[31:7] == '0);
endmodule

bind xlat_window_bank xlat_window_bank_chk #(
  .WIN_BASE(WIN_BASE), .LOCAL_AW(LOCAL_AW), .TGT_AW(TGT_AW),
  .PAGE_LSB(PAGE_LSB), .IDX_W(IDX_W)
) chk_i (
  .clk(clk), .rst_q_n(rst_q_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .req_valid(req_valid), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_addr(rsp_addr), .rsp_miss(rsp_miss), .rsp_win(rsp_win)
);

// File: tb/xlat_window_bank_tb_top.sv
module xlat_window_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic [39:0] req_addr = '0;
  logic        req_is_core = 1'b0;
  logic [2:0]  req_cpid = '0;
  logic        rsp_valid;
  logic [63:0] rsp_addr;
  logic        rsp_miss;
  logic [5:0]  rsp_win;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  xlat_window_bank dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .req_is_core(req_is_core), .req_cpid(req_cpid),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_miss(rsp_miss), .rsp_win(rsp_win)
  );

  function automatic logic [15:0] wa(input int w, input int ofs);
    return 16'(32'h2000 + w * 28 + ofs);
  endfunction

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    n_chk++;
    if (reg_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s: reg %h read %h expected %h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic prog(input int w, input logic [31:0] ctl, input logic [19:0] msk,
                      input logic [19:0] mat, input logic [43:0] rep);
    wr(wa(w, 0), 32'h0);
    wr(wa(w, 4),  {msk[11:0], 20'h0});
    wr(wa(w, 8),  {24'h0, msk[19:12]});
    wr(wa(w, 12), {mat[11:0], 20'h0});
    wr(wa(w, 16), {24'h0, mat[19:12]});
    wr(wa(w, 20), {rep[11:0], 20'h0});
    wr(wa(w, 24), rep[43:12]);
    wr(wa(w, 0), ctl);
  endtask

  task automatic req_chk(input logic [39:0] a, input logic core, input logic [2:0] id,
                         input logic [63:0] exp_a, input logic exp_m, input logic [5:0] exp_w,
                         input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_is_core = core; req_cpid = id;
    @(negedge clk);
    req_valid = 1'b0;
    n_chk++;
    if (rsp_valid !== 1'b1 || rsp_addr !== exp_a || rsp_miss !== exp_m || rsp_win !== exp_w) begin
      n_bad++;
      $display("FAIL %s: v=%b addr=%h miss=%b win=%0d expected v=1 addr=%h miss=%b win=%0d",
               tag, rsp_valid, rsp_addr, rsp_miss, rsp_win, exp_a, exp_m, exp_w);
    end
  endtask

  task automatic t_reset;
    rd_chk(wa(0, 0), 32'h0, "R2 reset ctrl w0");
    rd_chk(wa(39, 24), 32'h0, "R2 reset replace_hi w39");
    req_chk(40'hAB_CDEF_0123, 1'b1, 3'd0, 64'h0000_00AB_CDEF_0123, 1'b1, 6'd0,
            "R7 miss when empty");
  endtask

  task automatic t_fields;
    wr(wa(3, 0), 32'hFFFF_FFFF);
    rd_chk(wa(3, 0), 32'h0000_007F, "R2 ctrl reserved zero");
    wr(wa(3, 4), 32'hFFFF_FFFF);
    rd_chk(wa(3, 4), 32'hFFF0_0000, "R3 mask_lo field");
    wr(wa(3, 8), 32'hFFFF_FFFF);
    rd_chk(wa(3, 8), 32'h0000_00FF, "R3 mask_hi field");
    wr(wa(3, 16), 32'hFFFF_FFFF);
    rd_chk(wa(3, 16), 32'h0000_00FF, "R3 match_hi field");
    wr(wa(3, 24), 32'hFFFF_FFFF);
    rd_chk(wa(3, 24), 32'hFFFF_FFFF, "R4 replace_hi full width");
    rd_chk(wa(4, 0), 32'h0, "R1 neighbour ctrl untouched");
    wr(wa(3, 0), 32'h0);
  endtask

  task automatic t_hit;
    prog(5, 32'h1, 20'hFFFFF, 20'h12345, 44'hABC_DEF0_1234);
    req_chk({20'h12345, 20'h6789A}, 1'b1, 3'd0, {44'hABC_DEF0_1234, 20'h6789A}, 1'b0, 6'd5,
            "R5 R6 full-mask hit");
    req_chk({20'h12346, 20'h6789A}, 1'b0, 3'd1, {24'h0, 20'h12346, 20'h6789A}, 1'b1, 6'd0,
            "R7 one page off misses");
  endtask

  task automatic t_mask;
    prog(6, 32'h1, 20'hFFF00, 20'h77700, 44'h000_0000_0042);
    req_chk({20'h777AB, 20'h00001}, 1'b1, 3'd0, {44'h42, 20'h00001}, 1'b0, 6'd6,
            "R5 masked bits ignored");
    req_chk({20'h778AB, 20'h00001}, 1'b1, 3'd0, {24'h0, 20'h778AB, 20'h00001}, 1'b1, 6'd0,
            "R5 compared bit differs");
  endtask

  task automatic t_invalid;
    prog(7, 32'h0, 20'hFFFFF, 20'h0BEEF, 44'h111);
    req_chk({20'h0BEEF, 20'h00010}, 1'b1, 3'd0, {24'h0, 20'h0BEEF, 20'h00010}, 1'b1, 6'd0,
            "R8 disabled never hits");
    wr(wa(7, 0), 32'h1);
    req_chk({20'h0BEEF, 20'h00010}, 1'b1, 3'd0, {44'h111, 20'h00010}, 1'b0, 6'd7,
            "R8 enabled then hits");
  endtask

  task automatic t_priority;
    prog(20, 32'h1, 20'hFFFFF, 20'h55555, 44'h200);
    prog(10, 32'h1, 20'hFFFFF, 20'h55555, 44'h100);
    req_chk({20'h55555, 20'hFFFFF}, 1'b0, 3'd2, {44'h100, 20'hFFFFF}, 1'b0, 6'd10,
            "R9 lowest index wins");
    wr(wa(10, 0), 32'h0);
    req_chk({20'h55555, 20'hFFFFF}, 1'b0, 3'd2, {44'h200, 20'hFFFFF}, 1'b0, 6'd20,
            "R9 next window after disable");
  endtask

  task automatic t_gate;
    logic [39:0] a;
    a = {20'h33333, 20'h00ABC};
    prog(12, 32'h3, 20'hFFFFF, 20'h33333, 44'h333);
    req_chk(a, 1'b1, 3'd0, {44'h333, 20'h00ABC}, 1'b0, 6'd12, "R10 core passes");
    req_chk(a, 1'b0, 3'd0, {24'h0, a}, 1'b1, 6'd0, "R10 coprocessor blocked");
    wr(wa(12, 0), 32'h5);
    req_chk(a, 1'b1, 3'd0, {24'h0, a}, 1'b1, 6'd0, "R11 core blocked");
    req_chk(a, 1'b0, 3'd6, {44'h333, 20'h00ABC}, 1'b0, 6'd12, "R11 coprocessor passes");
    wr(wa(12, 0), 32'h59);
    req_chk(a, 1'b0, 3'd5, {44'h333, 20'h00ABC}, 1'b0, 6'd12, "R12 selected id passes");
    req_chk(a, 1'b0, 3'd4, {24'h0, a}, 1'b1, 6'd0, "R12 other id blocked");
    req_chk(a, 1'b1, 3'd5, {24'h0, a}, 1'b1, 6'd0, "R12 core blocked");
  endtask

  task automatic t_high;
    prog(39, 32'h1, 20'hFFFFF, 20'hF00D1, 44'hFED_CBA9_8765);
    rd_chk(16'h245C, 32'hFEDC_BA98, "R1 R4 last window replace_hi");
    req_chk({20'hF00D1, 20'h0F0F0}, 1'b0, 3'd0, {44'hFED_CBA9_8765, 20'h0F0F0}, 1'b0, 6'd39,
            "R4 wide replacement on window 39");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_fields;
    t_hit;
    t_mask;
    t_invalid;
    t_priority;
    t_gate;
    t_high;
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule